// File: doc/BRIEF.md
# Line-Synchronous Clamp Strobe Generator

This block produces one black-level clamp strobe per video line in the pixel clock domain. It watches a horizontal sync input that is already synchronous to the pixel clock and has its polarity corrected to active high. On each sync trailing edge it counts a programmable number of pixel periods, which places the strobe in the back porch. It then holds the strobe high for a programmable number of pixel periods.

Two 8-bit settings control the internal timing: the offset from the sync trailing edge, and the strobe length. Both settings are captured at the trailing edge, so a change during a line takes effect on the next line. A zero in either setting is treated as one.

A mode input can bypass the internal timing completely. In that mode the strobe is an external clamp input after a two-stage synchronizer, and the internal counter is held idle.

Top module: `clamp_strobe_gen`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first qualifying event, `clamp_o` is 0.
- R2: A trailing edge is the first rising clock edge at which `hsync_i` is sampled 0 after it was sampled 1 at the edge before. This edge is called edge k. In internal mode (`ext_mode_i` = 0) with an offset P of 1 to 255 on `placement_i`, `clamp_o` first goes high right after edge k+P.
- R3: In internal mode, a length D of 1 to 255 on `duration_i` holds `clamp_o` high for exactly D clock cycles. It falls right after edge k+P+D.
- R4: A value of 0 on `placement_i` or `duration_i` behaves exactly like a value of 1.
- R5: A new trailing edge that arrives while an offset or length count is running restarts the sequence. `clamp_o` is 0 right after the new edge k, and the new timing follows R2 and R3.
- R6: `placement_i` and `duration_i` are sampled only at edge k. Changing them later in the line does not alter that line's strobe.
- R7: In external mode (`ext_mode_i` = 1), `clamp_o` equals the value `ext_clamp_i` had two rising clock edges earlier. `placement_i`, `duration_i` and `hsync_i` have no effect on it.
- R8: While in external mode the internal generator stays idle. After a return to internal mode, `clamp_o` stays 0 until a trailing edge has been seen in internal mode.
- R9: A rising transition of `hsync_i`, or a steady level on it, never starts a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, active high, synchronous to clk_i |
| ext_mode_i | input | 1 | 1 selects the external clamp input, 0 selects internal timing |
| ext_clamp_i | input | 1 | External clamp request, asynchronous |
| placement_i | input | 8 | Offset in pixel periods from sync trailing edge to strobe start (0 acts as 1) |
| duration_i | input | 8 | Strobe length in pixel periods (0 acts as 1) |
| clamp_o | output | 1 | Clamp strobe |

## Verification
The bench drives each input just after a falling clock edge and samples `clamp_o` at every falling edge that follows edge k. The sample taken after edge k+j must be high exactly when P <= j < P+D, with zeros replaced by one. A run of offset and length pairs checks this in every cycle from j = 0 up to two cycles past the expected end of the strobe. In external mode the bench keeps the last two driven `ext_clamp_i` values and compares each sample with the value driven two falling edges earlier, which is two rising edges of the synchronizer. The restart and mid-line change cases use the same timing rule, counted from the edge that detects the second trailing edge.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  // Phase of the internal clamp sequencer.
  typedef enum logic [1:0] {
    CL_IDLE   = 2'd0,
    CL_DELAY  = 2'd1,
    CL_ACTIVE = 2'd2
  } clamp_phase_e;

endpackage

// File: rtl/clamp_edge_det.sv
module clamp_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);

  logic prev_q;
  logic prev_d;

  assign prev_d = sig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  // 1-to-0 transition between the previous and current samples.
  assign fall_o = prev_q & ~sig_i;

endmodule

// File: rtl/clamp_cfg_cap.sv
module clamp_cfg_cap #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] plc_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic [CNT_W-1:0] plc_o,
  output logic [CNT_W-1:0] dur_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] raw   [2];
  logic [CNT_W-1:0] clean [2];
  logic [CNT_W-1:0] dur_q;
  logic [CNT_W-1:0] dur_d;

  assign raw[0] = plc_i;
  assign raw[1] = dur_i;

  // A zero setting is replaced by one for both fields.
  for (genvar f = 0; f < 2; f++) begin : g_floor
    assign clean[f] = (raw[f] == '0) ? ONE : raw[f];
  end

  // The offset feeds the counter directly on the load cycle.
  assign plc_o = clean[0];

  assign dur_d = load_i ? clean[1] : dur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dur_q <= ONE;
    end else if (load_i) begin
      dur_q <= dur_d;
    end
  end

  assign dur_o = dur_q;

endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
  import clamp_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] plc_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             clamp_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  clamp_phase_e     phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             on_q, on_d;
  logic             tmr_en;
  logic             last_tick;

  assign last_tick = (cnt_q <= ONE);
  assign tmr_en    = hold_i | start_i | (phase_q != CL_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    on_d    = on_q;
    if (hold_i) begin
      phase_d = CL_IDLE;
      cnt_d   = '0;
      on_d    = 1'b0;
    end else if (start_i) begin
      phase_d = CL_DELAY;
      cnt_d   = plc_i;
      on_d    = 1'b0;
    end else begin
      unique case (phase_q)
        CL_DELAY: begin
          if (last_tick) begin
            phase_d = CL_ACTIVE;
            cnt_d   = dur_i;
            on_d    = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        CL_ACTIVE: begin
          if (last_tick) begin
            phase_d = CL_IDLE;
            cnt_d   = '0;
            on_d    = 1'b0;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: begin
          phase_d = CL_IDLE;
          cnt_d   = '0;
          on_d    = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= CL_IDLE;
      cnt_q   <= '0;
      on_q    <= 1'b0;
    end else if (tmr_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      on_q    <= on_d;
    end
  end

  assign clamp_o = on_q;

endmodule

// File: rtl/clamp_sync.sv
module clamp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign chain_d[s] = d_i;
    end else begin : g_next
      assign chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/clamp_strobe_gen.sv
module clamp_strobe_gen #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             ext_mode_i,
  input  logic             ext_clamp_i,
  input  logic [CNT_W-1:0] placement_i,
  input  logic [CNT_W-1:0] duration_i,
  output logic             clamp_o
);

  logic             hs_fall;
  logic             start;
  logic [CNT_W-1:0] plc_clean;
  logic [CNT_W-1:0] dur_held;
  logic             gen_clamp;
  logic             ext_sync;

  clamp_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (hsync_i),
    .fall_o (hs_fall)
  );

  // A trailing edge counts only in internal mode.
  assign start = hs_fall & ~ext_mode_i;

  clamp_cfg_cap #(.CNT_W(CNT_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .plc_i  (placement_i),
    .dur_i  (duration_i),
    .plc_o  (plc_clean),
    .dur_o  (dur_held)
  );

  clamp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (ext_mode_i),
    .start_i (start),
    .plc_i   (plc_clean),
    .dur_i   (dur_held),
    .clamp_o (gen_clamp)
  );

  clamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ext_clamp_i),
    .q_o    (ext_sync)
  );

  assign clamp_o = ext_mode_i ? ext_sync : gen_clamp;

endmodule

// File: rtl/clamp_strobe_gen_chk.sv
module clamp_strobe_gen_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hsync_i,
  input logic ext_mode_i,
  input logic ext_clamp_i,
  input logic gen_clamp,
  input logic clamp_o
);

  localparam int unsigned MAX_HI = (1 << CNT_W) - 1;

  logic [1:0]     since_q;
  logic [CNT_W:0] hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q  <= '0;
      hi_run_q <= '0;
    end else begin
      if (since_q != 2'd3) since_q <= since_q + 2'd1;
      if (!gen_clamp) hi_run_q <= '0;
      else if (hi_run_q <= (CNT_W+1)'(MAX_HI)) hi_run_q <= hi_run_q + 1'b1;
    end
  end

  // R1: output is low during reset.
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_low_r1: assert (clamp_o == 1'b0)
        else $error("p_reset_low_r1");
    end
  end

  // R5: a trailing edge in internal mode leaves the strobe low after it.
  p_fall_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd1 && !ext_mode_i && $past(hsync_i) && !hsync_i)
      |=> (ext_mode_i || !clamp_o));

  // R7: external mode forwards the input with a two-edge delay.
  p_ext_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd2 && ext_mode_i) |-> (clamp_o == $past(ext_clamp_i, 2)));

  // R8: internal generator is idle after any cycle in external mode.
  p_gen_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_mode_i |=> !gen_clamp);

  // R3: the internal strobe never exceeds the largest length.
  p_len_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run_q <= (CNT_W+1)'(MAX_HI));

endmodule

bind clamp_strobe_gen clamp_strobe_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hsync_i     (hsync_i),
  .ext_mode_i  (ext_mode_i),
  .ext_clamp_i (ext_clamp_i),
  .gen_clamp   (gen_clamp),
  .clamp_o     (clamp_o)
);

// File: tb/clamp_strobe_gen_test.sv
`timescale 1ns/1ps
module clamp_strobe_gen_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hsync;
  logic       ext_mode;
  logic       ext_clamp;
  logic [7:0] plc;
  logic [7:0] dur;
  logic       clamp;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  clamp_strobe_gen uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .hsync_i     (hsync),
    .ext_mode_i  (ext_mode),
    .ext_clamp_i (ext_clamp),
    .placement_i (plc),
    .duration_i  (dur),
    .clamp_o     (clamp)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: clamp_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int floor1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Called right after hsync was driven low at a negedge; checks samples
  // after edges k+0 .. k+jmax.
  task automatic watch(input int p, input int d, input int jmax, input string req);
    int pe = floor1(p);
    int de = floor1(d);
    for (int j = 0; j <= jmax; j++) begin
      @(negedge clk);
      check(clamp, (j >= pe) && (j < pe + de), req);
    end
  endtask

  task automatic line(input int p, input int d, input string req);
    @(negedge clk);
    hsync = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(clamp, 1'b0, "R9");
    end
    hsync = 1'b0;
    plc = 8'(p);
    dur = 8'(d);
    watch(p, d, floor1(p) + floor1(d) + 2, req);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; hsync = 1'b1; ext_mode = 1'b0; ext_clamp = 1'b0;
    plc = 8'd5; dur = 8'd5;
    repeat (3) @(negedge clk);
    check(clamp, 1'b0, "R1");
    rst_n = 1'b1;
    // R1/R9: hsync held high after reset starts nothing.
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(clamp, 1'b0, "R1");
    end

    // R2/R3 sweep of offset and length.
    for (int p = 1; p <= 12; p++)
      for (int d = 1; d <= 6; d++)
        line(p, d, "R2_R3");

    // R4: zero settings act as one.
    line(0, 4, "R4");
    line(3, 0, "R4");
    line(0, 0, "R4");
    // Extremes of the 8-bit range.
    line(255, 1, "R2");
    line(1, 255, "R3");
    line(255, 255, "R3");

    // R6: settings changed mid-line do not affect this line.
    @(negedge clk); hsync = 1'b1;
    repeat (2) @(negedge clk);
    hsync = 1'b0; plc = 8'd4; dur = 8'd3;
    @(negedge clk); check(clamp, 1'b0, "R6");
    plc = 8'd1; dur = 8'd20;
    watch(3, 3, 8, "R6");

    // R5: restart during the active phase.
    @(negedge clk); hsync = 1'b1;
    repeat (2) @(negedge clk);
    hsync = 1'b0; plc = 8'd10; dur = 8'd10;
    watch(10, 10, 12, "R5");
    hsync = 1'b1;
    @(negedge clk); check(clamp, 1'b1, "R5");
    hsync = 1'b0; plc = 8'd3; dur = 8'd4;
    watch(3, 4, 9, "R5");

    // R5: restart during the offset phase.
    @(negedge clk); hsync = 1'b1;
    @(negedge clk); hsync = 1'b0; plc = 8'd9; dur = 8'd2;
    watch(9, 2, 4, "R5");
    hsync = 1'b1;
    @(negedge clk); check(clamp, 1'b0, "R5");
    hsync = 1'b0; plc = 8'd2; dur = 8'd2;
    watch(2, 2, 6, "R5");

    // R7: external mode passes the synchronized input; sync and settings ignored.
    begin
      logic [7:0] lfsr = 8'hA5;
      logic h1 = 1'b0, h2 = 1'b0;
      @(negedge clk); ext_mode = 1'b1; plc = 8'd1; dur = 8'd1;
      ext_clamp = 1'b0;
      @(negedge clk);
      @(negedge clk);
      for (int i = 0; i < 60; i++) begin
        check(clamp, h2, "R7");
        h2 = h1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ext_clamp = lfsr[0];
        h1 = lfsr[0];
        hsync = lfsr[3];
        @(negedge clk);
      end
      ext_clamp = 1'b1; hsync = 1'b1;
      @(negedge clk); @(negedge clk);
      hsync = 1'b0;
      repeat (3) @(negedge clk);
      check(clamp, 1'b1, "R7");
    end

    // R8: back to internal mode, no strobe until a trailing edge.
    ext_mode = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(clamp, 1'b0, "R8");
    end
    line(2, 3, "R8");

    done = 1'b1;
    finish_run();
  end

endmodule